// File: doc/BRIEF.md
# Rectangle Solid Fill Engine

This block paints an axis-aligned rectangle of 8-bit pixels into a linear framebuffer with a single colour. Software loads two opposite corners, a colour and an operation code through a 32-bit write-only register port, then writes to a trigger location. When the operation code selects a fill, the engine walks the rectangle and emits one byte write per accepted beat on a valid/ready memory write port.

The two corners may be given in any order; each axis is sorted before the walk starts and both bounds are inclusive. The frame is 1280 pixels wide and 1024 rows high, based at byte address 0x3800_0000. A row is emitted only when its row number lies inside the frame and the left edge lies inside the frame. Such a row is always emitted at its full length, even if its right end runs past column 1279. The engine latches everything it needs at the trigger, so later register traffic cannot alter a fill in progress.

Top module: `rect_fill_engine`

## Requirements
- R1: While reset is asserted and in the cycle after it, `busy` and `mem_valid` are low.
- R2: A write of any data to offset 0x21F8 starts a fill when bits 31:24 of the last value written to offset 0x2060 equal 3. Bits 7:0 of that register do not select the operation.
- R3: A trigger while the operation byte holds any value other than 3, including the no-op value 1, produces no memory write and leaves `busy` low.
- R4: If the second corner's X is smaller than the first corner's X, the two X values are swapped before the walk. The same rule applies to Y. The result is the same rectangle whatever the corner order.
- R5: Corner one is at offset 0x2070 and corner two is at offset 0x2074. In both, X is in bits 27:16 and Y is in bits 11:0. Each pixel write goes to address 0x3800_0000 + X + 1280*Y. Its data is bits 7:0 of offset 0x20D0.
- R6: Rows are emitted from the smallest Y upward. Within a row, pixels go from the smallest X to the largest X. Exactly one byte is written per beat on which `mem_valid` and `mem_ready` are both high.
- R7: Rows with Y of 1024 or more are skipped. No row is emitted when the smaller X is 1280 or more. A row whose left edge is inside the frame is emitted at its full length.
- R8: While `mem_valid` is high and `mem_ready` is low, `mem_valid`, `mem_addr` and `mem_data` hold their values into the next cycle.
- R9: Register writes and triggers while `busy` is high change neither the rectangle nor the colour being written, and start no second fill.
- R10: `busy` rises in the cycle after an accepted trigger and falls in the cycle after the last accepted beat. `mem_valid` is never high without `busy`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 14 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| busy | output | 1 | Fill in progress |
| mem_valid | output | 1 | Memory write beat valid |
| mem_ready | input | 1 | Memory side accepts the beat |
| mem_addr | output | 32 | Byte address of the pixel |
| mem_data | output | 8 | Pixel colour |

## Verification
The bench aims at corners given in reverse order. A design that did not sort them would emit nothing, or would walk down and leftward through unrelated memory. It fills across the bottom edge of the frame and starts a fill beyond the right edge. A wrong clip would write rows past 1023 or drop the whole rectangle. It also checks a row that starts inside the frame and spills past column 1279, which a design clipping per pixel would cut short. Stalled beats catch an address that advances without a handshake, and register writes plus a second trigger during a fill catch a design that re-reads live registers or restarts mid-walk.

// File: rtl/rfe_pkg.sv
package rfe_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } rfe_state_e;

  localparam logic [7:0] OPC_FILL = 8'd3;
endpackage

// File: rtl/rfe_regs.sv
module rfe_regs #(
  parameter int unsigned        RAW     = 14,
  parameter int unsigned        CW      = 12,
  parameter int unsigned        X_LSB   = 16,
  parameter logic [RAW-1:0]     OFS_OP  = 14'h2060,
  parameter logic [RAW-1:0]     OFS_C1  = 14'h2070,
  parameter logic [RAW-1:0]     OFS_C2  = 14'h2074,
  parameter logic [RAW-1:0]     OFS_COL = 14'h20d0,
  parameter logic [RAW-1:0]     OFS_GO  = 14'h21f8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           reg_wr,
  input  logic [RAW-1:0] reg_addr,
  input  logic [31:0]    reg_wdata,
  input  logic           busy,
  output logic [CW-1:0]  ax,
  output logic [CW-1:0]  ay,
  output logic [CW-1:0]  bx,
  output logic [CW-1:0]  by,
  output logic [7:0]     colour,
  output logic           start
);
  import rfe_pkg::*;

  logic [7:0] opc_q;
  logic       unused_bits;

  assign unused_bits = ^reg_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      opc_q  <= '0;
      ax     <= '0;
      ay     <= '0;
      bx     <= '0;
      by     <= '0;
      colour <= '0;
    end else if (reg_wr) begin
      if (reg_addr == OFS_OP)  opc_q  <= reg_wdata[31:24];
      if (reg_addr == OFS_C1) begin
        ax <= reg_wdata[X_LSB +: CW];
        ay <= reg_wdata[0 +: CW];
      end
      if (reg_addr == OFS_C2) begin
        bx <= reg_wdata[X_LSB +: CW];
        by <= reg_wdata[0 +: CW];
      end
      if (reg_addr == OFS_COL) colour <= reg_wdata[7:0];
    end
  end

  assign start = reg_wr && (reg_addr == OFS_GO) && (opc_q == OPC_FILL) && !busy;
endmodule

// File: rtl/rfe_sort2.sv
module rfe_sort2 #(
  parameter int unsigned W = 12
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] lo,
  output logic [W-1:0] hi
);
  logic swap;
  assign swap = (b < a);
  assign lo   = swap ? b : a;
  assign hi   = swap ? a : b;
endmodule

// File: rtl/rfe_walker.sv
module rfe_walker #(
  parameter int unsigned    CW      = 12,
  parameter int unsigned    AW      = 32,
  parameter int unsigned    FB_W    = 1280,
  parameter int unsigned    FB_H    = 1024,
  parameter logic [AW-1:0]  FB_BASE = 32'h3800_0000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [CW-1:0] x_lo,
  input  logic [CW-1:0] x_hi,
  input  logic [CW-1:0] y_lo,
  input  logic [CW-1:0] y_hi,
  input  logic [7:0]    colour,
  input  logic          mem_ready,
  output logic          mem_valid,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_data,
  output logic          busy
);
  import rfe_pkg::*;

  localparam logic [CW:0]   W_LIM    = (CW+1)'(FB_W);
  localparam logic [CW:0]   H_LIM    = (CW+1)'(FB_H);
  localparam logic [CW-1:0] LAST_ROW = CW'(FB_H - 1);
  localparam logic [AW-1:0] STRIDE   = AW'(FB_W);

  rfe_state_e    state_q;
  logic [CW-1:0] x_q, y_q, xlo_q, xhi_q, yend_q;
  logic [AW-1:0] row_q, addr_q;
  logic [7:0]    col_q;

  logic          skip_n;
  logic [CW-1:0] yend_n;
  logic [AW-1:0] row_n;

  assign skip_n = ({1'b0, x_lo} >= W_LIM) || ({1'b0, y_lo} >= H_LIM);
  assign yend_n = (y_hi > LAST_ROW) ? LAST_ROW : y_hi;
  assign row_n  = FB_BASE + AW'(y_lo) * STRIDE;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      x_q     <= '0;
      y_q     <= '0;
      xlo_q   <= '0;
      xhi_q   <= '0;
      yend_q  <= '0;
      row_q   <= '0;
      addr_q  <= '0;
      col_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            x_q     <= x_lo;
            y_q     <= y_lo;
            xlo_q   <= x_lo;
            xhi_q   <= x_hi;
            yend_q  <= yend_n;
            row_q   <= row_n;
            addr_q  <= row_n + AW'(x_lo);
            col_q   <= colour;
            state_q <= skip_n ? ST_DONE : ST_RUN;
          end
        end
        ST_RUN: begin
          if (mem_ready) begin
            if (x_q == xhi_q) begin
              if (y_q == yend_q) begin
                state_q <= ST_IDLE;
              end else begin
                y_q    <= y_q + 1'b1;
                x_q    <= xlo_q;
                row_q  <= row_q + STRIDE;
                addr_q <= row_q + STRIDE + AW'(xlo_q);
              end
            end else begin
              x_q    <= x_q + 1'b1;
              addr_q <= addr_q + 1'b1;
            end
          end
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_valid = (state_q == ST_RUN);
  assign busy      = (state_q != ST_IDLE);
  assign mem_addr  = addr_q;
  assign mem_data  = col_q;
endmodule

// File: rtl/rect_fill_engine.sv
module rect_fill_engine #(
  parameter int unsigned    RAW     = 14,
  parameter int unsigned    AW      = 32,
  parameter int unsigned    CW      = 12,
  parameter int unsigned    X_LSB   = 16,
  parameter int unsigned    FB_W    = 1280,
  parameter int unsigned    FB_H    = 1024,
  parameter logic [AW-1:0]  FB_BASE = 32'h3800_0000
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           reg_wr,
  input  logic [RAW-1:0] reg_addr,
  input  logic [31:0]    reg_wdata,
  output logic           busy,
  output logic           mem_valid,
  input  logic           mem_ready,
  output logic [AW-1:0]  mem_addr,
  output logic [7:0]     mem_data
);
  logic [CW-1:0] ax, ay, bx, by;
  logic [CW-1:0] xl, xh, yl, yh;
  logic [7:0]    colour;
  logic          start;

  rfe_regs #(.RAW(RAW), .CW(CW), .X_LSB(X_LSB)) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .busy(busy),
    .ax(ax), .ay(ay), .bx(bx), .by(by), .colour(colour), .start(start)
  );

  rfe_sort2 #(.W(CW)) u_sort_x (.a(ax), .b(bx), .lo(xl), .hi(xh));
  rfe_sort2 #(.W(CW)) u_sort_y (.a(ay), .b(by), .lo(yl), .hi(yh));

  rfe_walker #(
    .CW(CW), .AW(AW), .FB_W(FB_W), .FB_H(FB_H), .FB_BASE(FB_BASE)
  ) u_walk (
    .clk(clk), .rst(rst), .start(start),
    .x_lo(xl), .x_hi(xh), .y_lo(yl), .y_hi(yh), .colour(colour),
    .mem_ready(mem_ready), .mem_valid(mem_valid), .mem_addr(mem_addr),
    .mem_data(mem_data), .busy(busy)
  );
endmodule

// File: rtl/rfe_checker.sv
module rfe_checker #(
  parameter int unsigned   AW      = 32,
  parameter int unsigned   FB_W    = 1280,
  parameter int unsigned   FB_H    = 1024,
  parameter logic [AW-1:0] FB_BASE = 32'h3800_0000
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          mem_valid,
  input logic          mem_ready,
  input logic [AW-1:0] mem_addr,
  input logic [7:0]    mem_data
);
  localparam logic [AW-1:0] ADDR_TOP = FB_BASE + AW'(FB_W * FB_H) + AW'(4096);

  AST_RESET_IDLE: assert property (@(posedge clk)
    rst |=> (!mem_valid && !busy)); // R1

  AST_VALID_NEEDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> busy); // R10

  AST_HOLD_ON_STALL: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_data))); // R8

  AST_COLOUR_STEADY: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && $past(mem_valid)) |-> $stable(mem_data)); // R9

  AST_ADDR_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
    mem_valid |-> (mem_addr >= FB_BASE && mem_addr < ADDR_TOP)); // R7
endmodule

bind rect_fill_engine rfe_checker #(
  .AW(AW), .FB_W(FB_W), .FB_H(FB_H), .FB_BASE(FB_BASE)
) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .mem_valid(mem_valid),
  .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data)
);

// File: tb/test_rect_fill_engine.sv
`timescale 1ns/1ps
module test_rect_fill_engine;
  localparam logic [13:0] A_OP  = 14'h2060;
  localparam logic [13:0] A_C1  = 14'h2070;
  localparam logic [13:0] A_C2  = 14'h2074;
  localparam logic [13:0] A_COL = 14'h20d0;
  localparam logic [13:0] A_GO  = 14'h21f8;
  localparam longint BASE = 64'h3800_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [13:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        busy, mem_valid;
  logic        mem_ready = 1'b1;
  logic [31:0] mem_addr;
  logic [7:0]  mem_data;

  always #2 clk = ~clk;

  rect_fill_engine i_rect_fill_engine (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .busy(busy), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_addr(mem_addr), .mem_data(mem_data)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] got_a [0:4095];
  logic [7:0]  got_d [0:4095];
  int got_n;
  int stall_err;
  bit last_hs;
  bit first_busy;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [13:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic setup(input int x1, input int y1, input int x2, input int y2,
                       input logic [7:0] col, input logic [7:0] op);
    wr(A_C1, {4'h0, 12'(x1), 4'h0, 12'(y1)});
    wr(A_C2, {4'h0, 12'(x2), 4'h0, 12'(y2)});
    wr(A_COL, {24'hABCDEF, col});
    wr(A_OP, {op, 24'h000003});
  endtask

  // Called at the negedge right after the trigger write.
  task automatic collect(input bit stall);
    bit r, pend;
    logic [31:0] ha;
    logic [7:0]  hd;
    got_n = 0; stall_err = 0; last_hs = 0; pend = 0;
    first_busy = busy;
    for (int cyc = 0; cyc < 20000; cyc++) begin
      if (!busy) break;
      if (pend && !(mem_valid && mem_addr == ha && mem_data == hd)) stall_err++;
      pend = 0;
      r = stall ? (cyc % 3 != 1) : 1'b1;
      mem_ready = r;
      if (mem_valid && r && got_n < 4096) begin
        got_a[got_n] = mem_addr;
        got_d[got_n] = mem_data;
        got_n++;
      end
      if (mem_valid && !r) begin
        pend = 1; ha = mem_addr; hd = mem_data;
      end
      last_hs = mem_valid && r;
      @(negedge clk);
    end
    mem_ready = 1'b1;
  endtask

  task automatic expect_rect(input int x1, input int y1, input int x2, input int y2,
                             input logic [7:0] col, input string req);
    int xl, xh, yl, yh, idx, bad_i;
    longint ea;
    xl = (x2 < x1) ? x2 : x1; xh = (x2 < x1) ? x1 : x2;
    yl = (y2 < y1) ? y2 : y1; yh = (y2 < y1) ? y1 : y2;
    idx = 0; bad_i = -1; ea = 0;
    for (int y = yl; y <= yh; y++) begin
      if (xl < 1280 && y < 1024) begin
        for (int x = xl; x <= xh; x++) begin
          if (bad_i < 0 && idx < got_n &&
              (longint'(got_a[idx]) != BASE + x + 1280*y || got_d[idx] != col)) begin
            bad_i = idx; ea = BASE + x + 1280*y;
          end
          idx++;
        end
      end
    end
    check(got_n == idx, req, "beat count", got_n, idx);
    if (bad_i >= 0)
      check(0, req, "address/data order", {got_d[bad_i], got_a[bad_i]}, {col, ea[31:0]});
    else
      check(1, req, "address/data order", 0, 0);
    if (idx > 0) begin
      check(first_busy, "R10", "busy after trigger", first_busy, 1);
      check(last_hs, "R10", "busy drop after last beat", last_hs, 1);
    end
  endtask

  task automatic t_reset;
    check(!busy, "R1", "busy after reset", busy, 0);
    check(!mem_valid, "R1", "valid after reset", mem_valid, 0);
  endtask

  task automatic t_basic;
    setup(10, 5, 12, 6, 8'hA5, 8'd3);
    wr(A_GO, 32'h0);
    collect(0);
    expect_rect(10, 5, 12, 6, 8'hA5, "R2 R5 R6");
  endtask

  task automatic t_swap_stall;
    setup(12, 6, 10, 5, 8'h3C, 8'd3);
    wr(A_GO, 32'h1);
    collect(1);
    expect_rect(10, 5, 12, 6, 8'h3C, "R4");
    check(stall_err == 0, "R8", "hold under stall", stall_err, 0);
  endtask

  task automatic t_noop(input logic [7:0] op);
    int seen;
    seen = 0;
    setup(0, 0, 3, 3, 8'hFF, op);
    wr(A_GO, 32'h0);
    for (int i = 0; i < 12; i++) begin
      if (busy || mem_valid) seen++;
      @(negedge clk);
    end
    check(seen == 0, "R3", "no activity for non-fill op", seen, 0);
  endtask

  task automatic t_low_byte_op;
    int seen;
    seen = 0;
    setup(0, 0, 1, 1, 8'h77, 8'd0);
    wr(A_OP, 32'h0000_0003);
    wr(A_GO, 32'h0);
    for (int i = 0; i < 8; i++) begin
      if (busy || mem_valid) seen++;
      @(negedge clk);
    end
    check(seen == 0, "R2", "op in low byte ignored", seen, 0);
  endtask

  task automatic t_clip;
    setup(100, 1025, 101, 1022, 8'h5A, 8'd3);
    wr(A_GO, 32'h0);
    collect(0);
    expect_rect(100, 1022, 101, 1025, 8'h5A, "R7 bottom");
    setup(1300, 0, 1302, 1, 8'h12, 8'd3);
    wr(A_GO, 32'h0);
    collect(0);
    check(got_n == 0, "R7", "right of frame", got_n, 0);
    setup(1278, 0, 1281, 0, 8'h34, 8'd3);
    wr(A_GO, 32'h0);
    collect(0);
    expect_rect(1278, 0, 1281, 0, 8'h34, "R7 spill");
  endtask

  task automatic t_busy_writes;
    setup(20, 30, 27, 33, 8'h11, 8'd3);
    wr(A_GO, 32'h0);
    fork
      collect(1);
      begin
        wr(A_C1, {4'h0, 12'd0, 4'h0, 12'd0});
        wr(A_COL, 32'h0000_00EE);
        wr(A_GO, 32'h0);
        wr(A_C2, {4'h0, 12'd2, 4'h0, 12'd2});
        wr(A_GO, 32'h0);
      end
    join
    expect_rect(20, 30, 27, 33, 8'h11, "R9");
    check(!busy, "R9", "no second fill", busy, 0);
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_bad++;
    $display("FAIL R10 watchdog expired: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_swap_stall();
    t_noop(8'd1);
    t_noop(8'd7);
    t_low_byte_op();
    t_clip();
    t_busy_writes();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule